// File: doc/BRIEF.md
# Paddle Position Charge Timer

This block turns the charge time of up to eight external RC paddle networks into digital position readings. A start strobe begins a scan. At the start of a scan the block releases every line's discharge control, so each capacitor starts to charge. One shared counter then advances once per scan-line tick. Each line owns a comparator input, and the first time that input is seen high during a scan, the line stores the current count and raises its done flag.

The counter stops at a fixed ceiling (228 by default). At that point the scan ends. Any line that has not crossed its threshold is given the ceiling value, and all discharge controls are driven again. The latched readings stay available on a flat output bus and on a selectable read port until the line captures a new value. A new start strobe may arrive at any time, and it always restarts the scan from zero.

Top module: `paddle_timer`

## Requirements
- R1: After reset every dump output is 1, every done bit is 0 and every latched value reads 0.
- R2: On the clock edge that samples start high, all done bits clear and all dump outputs go to 0 for the whole scan.
- R3: The scan counter starts at 0 and advances by one only on edges where the line tick is high while a scan runs.
- R4: A line whose threshold input is sampled high during a scan while its done bit is 0 latches the current count and sets its done bit on that edge.
- R5: Once a line's done bit is set, further threshold activity on that line changes neither its latch nor its done bit until the next start.
- R6: On the tick that brings the count to the ceiling (228), every line that is not yet done latches 228 and sets its done bit.
- R7: When the ceiling is reached, all dump outputs return to 1 and the counter holds; ticks and thresholds have no effect until the next start.
- R8: A start during a running scan clears the counter and all done bits and keeps the dump outputs at 0. A capture after the restart reports a count measured from the restart.
- R9: Each latch keeps its value across scans until that line captures again. It is readable at all times on the flat bus (line i at bits i*8+7..i*8) and on the read port (rd_data shows line rd_sel, with no clock delay).
- R10: When start and a threshold are sampled high on the same edge, the start takes effect and no capture happens on that edge.
- R11: When a threshold and the final tick are sampled on the same edge, the line captures the count before the increment (227), and the other lines receive 228.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Scan start / restart strobe |
| line_tick_i | input | 1 | One-cycle pulse per scan line |
| thresh_i | input | 8 | Comparator outputs, one per line |
| dump_o | output | 8 | Discharge enable per line, 1 = hold capacitor at zero |
| done_o | output | 8 | Per-line capture complete |
| latch_o | output | 64 | All latched counts, line i at bits i*8+7..i*8 |
| rd_sel_i | input | 3 | Line select for the read port |
| rd_data_o | output | 8 | Latched count of the selected line |

## Verification
On every cycle, the assertions check these properties:
- the counter never passes the ceiling;
- the counter does not move without a tick or outside a scan;
- a restart zeroes it;
- a done line's latch and flag stay frozen;
- all lines are done one cycle after the ceiling;
- the dump outputs match the scan state.

Only the bench's scenarios can show that the captured numbers are right. This covers the exact count a line stores relative to the ticks seen since start, the pre-increment value on the final tick, the 228 fill, and the priority of start over a simultaneous capture. It also covers values kept across later scans and the read port selection.

// File: rtl/paddle_timer_pkg.sv
package paddle_timer_pkg;

   typedef enum logic {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_e;

   function automatic bit limit_fits(input int cnt_w, input int limit);
      return (limit > 1) && (limit < (1 << cnt_w));
   endfunction

endpackage

// File: rtl/ptm_scan_ctrl.sv
module ptm_scan_ctrl
   import paddle_timer_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int SCAN_LIMIT = 228
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             tick_i,
   output logic             active_o,
   output logic             finish_o,
   output logic [CNT_W-1:0] count_o
);

   localparam logic [CNT_W-1:0] LIM  = CNT_W'(SCAN_LIMIT);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SCAN_LIMIT - 1);

   initial begin : elab_chk
      assert (limit_fits(CNT_W, SCAN_LIMIT))
         else $error("ptm_scan_ctrl: SCAN_LIMIT does not fit CNT_W");
   end

   scan_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             running;
   logic             step;

   assign running  = (state_q == SCAN_RUN);
   assign step     = running && tick_i && !start_i;
   assign finish_o = step && (cnt_q == LAST);
   assign active_o = running;
   assign count_o  = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SCAN_IDLE;
         cnt_q   <= '0;
      end else if (start_i) begin
         state_q <= SCAN_RUN;
         cnt_q   <= '0;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
         if (finish_o) begin
            state_q <= SCAN_IDLE;
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM); // R3
   AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !tick_i && !start_i) |=> $stable(cnt_q)); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !start_i) |=> ($stable(cnt_q) && !active_o)); // R7
   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (cnt_q == '0 && active_o)); // R8

endmodule

// File: rtl/ptm_line_cell.sv
module ptm_line_cell #(
   parameter int CNT_W      = 8,
   parameter int SCAN_LIMIT = 228
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             active_i,
   input  logic             finish_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             thresh_i,
   output logic [CNT_W-1:0] latch_o,
   output logic             done_o,
   output logic             dump_o
);

   localparam logic [CNT_W-1:0] FILL = CNT_W'(SCAN_LIMIT);

   logic [CNT_W-1:0] latch_q;
   logic             done_q;
   logic             dump_q;
   logic             grab;
   logic             fill;

   assign grab = active_i && !restart_i && !done_q && thresh_i;
   assign fill = finish_i && !done_q && !grab;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '0;
         done_q  <= 1'b0;
         dump_q  <= 1'b1;
      end else if (restart_i) begin
         done_q <= 1'b0;
         dump_q <= 1'b0;
      end else begin
         if (grab) begin
            latch_q <= count_i;
            done_q  <= 1'b1;
         end else if (fill) begin
            latch_q <= FILL;
            done_q  <= 1'b1;
         end
         if (finish_i) begin
            dump_q <= 1'b1;
         end
      end
   end

   assign latch_o = latch_q;
   assign done_o  = done_q;
   assign dump_o  = dump_q;

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !restart_i) |=> done_q); // R5
   AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !restart_i) |=> $stable(latch_q)); // R5
   AST_FILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      finish_i |=> done_q); // R6

endmodule

// File: rtl/ptm_read_mux.sv
module ptm_read_mux #(
   parameter int NUM_LINES = 8,
   parameter int CNT_W     = 8,
   parameter int SEL_W     = 3
) (
   input  logic [NUM_LINES*CNT_W-1:0] lines_i,
   input  logic [SEL_W-1:0]           sel_i,
   output logic [CNT_W-1:0]           data_o
);

   localparam int SEL_SPAN = 1 << SEL_W;

   logic [SEL_SPAN-1:0][CNT_W-1:0] padded;

   generate
      genvar gi;
      for (gi = 0; gi < SEL_SPAN; gi++) begin : g_pad
         if (gi < NUM_LINES) begin : g_real
            assign padded[gi] = lines_i[gi*CNT_W +: CNT_W];
         end else begin : g_empty
            assign padded[gi] = '0;
         end
      end
   endgenerate

   assign data_o = padded[sel_i];

endmodule

// File: rtl/paddle_timer.sv
module paddle_timer #(
   parameter int NUM_LINES  = 8,
   parameter int CNT_W      = 8,
   parameter int SCAN_LIMIT = 228,
   localparam int SEL_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic                       line_tick_i,
   input  logic [NUM_LINES-1:0]       thresh_i,
   output logic [NUM_LINES-1:0]       dump_o,
   output logic [NUM_LINES-1:0]       done_o,
   output logic [NUM_LINES*CNT_W-1:0] latch_o,
   input  logic [SEL_W-1:0]           rd_sel_i,
   output logic [CNT_W-1:0]           rd_data_o
);

   initial begin : elab_chk
      assert (NUM_LINES >= 1 && NUM_LINES <= 64)
         else $error("paddle_timer: NUM_LINES out of range");
      assert (CNT_W >= 2 && CNT_W <= 16)
         else $error("paddle_timer: CNT_W out of range");
   end

   logic             active;
   logic             finish;
   logic [CNT_W-1:0] count;

   ptm_scan_ctrl #(
      .CNT_W      (CNT_W),
      .SCAN_LIMIT (SCAN_LIMIT)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .tick_i   (line_tick_i),
      .active_o (active),
      .finish_o (finish),
      .count_o  (count)
   );

   generate
      genvar li;
      for (li = 0; li < NUM_LINES; li++) begin : g_line
         ptm_line_cell #(
            .CNT_W      (CNT_W),
            .SCAN_LIMIT (SCAN_LIMIT)
         ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (start_i),
            .active_i  (active),
            .finish_i  (finish),
            .count_i   (count),
            .thresh_i  (thresh_i[li]),
            .latch_o   (latch_o[li*CNT_W +: CNT_W]),
            .done_o    (done_o[li]),
            .dump_o    (dump_o[li])
         );
      end
   endgenerate

   ptm_read_mux #(
      .NUM_LINES (NUM_LINES),
      .CNT_W     (CNT_W),
      .SEL_W     (SEL_W)
   ) u_rd (
      .lines_i (latch_o),
      .sel_i   (rd_sel_i),
      .data_o  (rd_data_o)
   );

   AST_DUMP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (dump_o == '0)); // R2
   AST_DUMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (&dump_o)); // R7
   AST_ALL_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> (&done_o)); // R6
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (done_o == '0)); // R10

endmodule

// File: tb/paddle_timer_bench.sv
`timescale 1ns/1ps
module paddle_timer_bench;

   localparam int N   = 8;
   localparam int W   = 8;
   localparam int LIM = 228;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start_i = 1'b0;
   logic           line_tick_i = 1'b0;
   logic [N-1:0]   thresh_i = '0;
   logic [N-1:0]   dump_o;
   logic [N-1:0]   done_o;
   logic [N*W-1:0] latch_o;
   logic [2:0]     rd_sel_i = '0;
   logic [W-1:0]   rd_data_o;

   int n_checks = 0;
   int n_fails  = 0;

   // reference state
   bit           m_active;
   int           m_cnt;
   logic [N-1:0] m_done;
   logic [N-1:0] m_dump;
   logic [W-1:0] m_lat [N];

   always #2 clk = ~clk;

   paddle_timer u_paddle_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .line_tick_i (line_tick_i),
      .thresh_i    (thresh_i),
      .dump_o      (dump_o),
      .done_o      (done_o),
      .latch_o     (latch_o),
      .rd_sel_i    (rd_sel_i),
      .rd_data_o   (rd_data_o)
   );

   task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] lat_of(input int i);
      return latch_o[i*W +: W];
   endfunction

   task automatic model_reset();
      m_active = 0;
      m_cnt    = 0;
      m_done   = '0;
      m_dump   = '1;
      for (int i = 0; i < N; i++) m_lat[i] = '0;
   endtask

   task automatic model_step(input logic st, input logic tk, input logic [N-1:0] th);
      bit fin;
      if (st) begin
         m_active = 1;
         m_cnt    = 0;
         m_done   = '0;
         m_dump   = '0;
      end else if (m_active) begin
         for (int i = 0; i < N; i++) begin
            if (!m_done[i] && th[i]) begin
               m_lat[i]  = W'(m_cnt);
               m_done[i] = 1'b1;
            end
         end
         fin = tk && (m_cnt == LIM - 1);
         if (tk) m_cnt++;
         if (fin) begin
            for (int i = 0; i < N; i++) begin
               if (!m_done[i]) begin
                  m_lat[i]  = W'(LIM);
                  m_done[i] = 1'b1;
               end
            end
            m_active = 0;
            m_dump   = '1;
         end
      end
   endtask

   task automatic compare_all();
      check(dump_o, m_dump, "R7 dump");
      check(done_o, m_done, "R4 done");
      for (int i = 0; i < N; i++) check(lat_of(i), m_lat[i], "R9 latch");
      check(rd_data_o, m_lat[rd_sel_i], "R9 read port");
   endtask

   task automatic cyc(input logic st, input logic tk, input logic [N-1:0] th);
      start_i     = st;
      line_tick_i = tk;
      thresh_i    = th;
      rd_sel_i    = 3'($urandom % N);
      @(posedge clk);
      model_step(st, tk, th);
      @(negedge clk);
      compare_all();
   endtask

   initial begin : watchdog
      #(4 * 190000);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check(dump_o, 8'hFF, "R1 dump");
      check(done_o, 8'h00, "R1 done");
      check(latch_o, 64'h0, "R1 latches");
      rst_n = 1'b1;

      // R10 start with threshold on the same edge
      cyc(1, 0, 8'h08);
      check(done_o, 8'h00, "R10 no capture with start");
      check(dump_o, 8'h00, "R2 dumps released");
      cyc(0, 0, 8'h08);
      check(lat_of(3), 8'd0, "R4 capture at zero");
      check(done_o[3], 1'b1, "R4 done set");
      repeat (5) cyc(0, 1, 8'h00);
      cyc(0, 0, 8'h01);
      check(lat_of(0), 8'd5, "R3 count equals ticks");
      cyc(0, 1, 8'h01);
      cyc(0, 1, 8'h00);
      cyc(0, 0, 8'h01);
      check(lat_of(0), 8'd5, "R5 later edges ignored");
      repeat (220) cyc(0, 1, 8'h00);
      cyc(0, 1, 8'h02);
      check(lat_of(1), 8'd227, "R11 final tick capture");
      check(lat_of(2), 8'd228, "R6 ceiling fill");
      check(done_o, 8'hFF, "R6 all done");
      check(dump_o, 8'hFF, "R7 dumps reasserted");
      repeat (4) cyc(0, 1, 8'h04);
      check(lat_of(2), 8'd228, "R7 held after end");

      // R8 restart mid-scan
      cyc(1, 0, 8'h00);
      repeat (10) cyc(0, 1, 8'h00);
      cyc(1, 0, 8'h00);
      check(done_o, 8'h00, "R8 done cleared");
      check(dump_o, 8'h00, "R8 dumps released");
      cyc(0, 0, 8'h10);
      check(lat_of(4), 8'd0, "R8 counter cleared");
      rd_sel_i = 3'd0;
      #1;
      check(rd_data_o, 8'd5, "R9 value retained on read port");

      // constrained random scans
      for (int s = 0; s < 30; s++) begin
         cyc(1, 1'($urandom % 2), 8'h00);
         for (int c = 0; c < 2000 && m_active; c++) begin
            logic [N-1:0] th;
            for (int b = 0; b < N; b++) th[b] = ($urandom % 80) == 0;
            cyc(($urandom % 1500) == 0, 1'($urandom % 2), th);
         end
         repeat (3) cyc(0, 1'($urandom % 2), N'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule